// File: doc/BRIEF.md
# Receive Delay-Line Bring-Up and Phase Sequencer

This block owns the control word of a receive delay-locked loop used to sample read data at high bus rates. It runs two fixed sequences, one register step per clock cycle. The initialisation sequence does the following in order:

- drops clock power-save;
- holds the loop in reset and power-down;
- loads a frequency band code derived from the interface clock rate;
- releases reset and power-down;
- enables the loop and its clock output;
- polls the lock status.

The phase sequence moves the clock-data-recovery path onto an externally chosen sampling phase. It parks recovery under an external select, waits for the clock output to stop, writes the phase in reflected Gray code, restarts the clock output, waits for it to run, and hands control back to recovery.

Every wait polls its status input once per microsecond, counted with a divider of the block clock, for at most a fixed number of polls. A wait that runs out of polls ends the sequence with an error. The block's states are:

- `ST_IDLE`;
- the initialisation states `ST_I_PSAVE_OFF`, `ST_I_RST_SET`, `ST_I_PDN_SET`, `ST_I_FREQ`, `ST_I_RST_CLR`, `ST_I_PDN_CLR`, `ST_I_LOOP_EN`, `ST_I_CKO_SET`, `ST_I_LOCK_WAIT` and `ST_I_PSAVE_ON`;
- the phase states `ST_P_PREP`, `ST_P_CKO_LOW_WAIT`, `ST_P_SEL_WRITE`, `ST_P_CKO_SET`, `ST_P_CKO_HIGH_WAIT` and `ST_P_CDR_ON`.

Each step state moves unconditionally to the next one in the lists above. The moves out of the wait states are these:

- `ST_I_LOCK_WAIT` goes to `ST_I_PSAVE_ON` on lock or on expiry.
- `ST_P_CKO_LOW_WAIT` goes to `ST_P_SEL_WRITE` on a hit, or back to `ST_IDLE` on expiry.
- `ST_P_CKO_HIGH_WAIT` goes to `ST_P_CDR_ON` on a hit, or back to `ST_IDLE` on expiry.
- `ST_I_PSAVE_ON` and `ST_P_CDR_ON` return to `ST_IDLE`.

Top module: `rxdl_sequencer`

## Requirements
- R1: After reset `dll_cfg` is 0, `clk_pwrsave` is 1, and `busy`, `seq_done` and `seq_err` are 0.
- R2: An init request sampled in idle produces these values, one per cycle after the sampling edge:
  - `clk_pwrsave` drops;
  - reset (bit 30) rises;
  - power-down (bit 29) rises;
  - the band code loads;
  - reset falls;
  - power-down falls;
  - loop enable (bit 16) rises;
  - clock-output enable (bit 18) rises.

  `busy` is 1 from the first cycle after the request until done.
- R3: The band code sits in bits 26:24. The rate in MHz maps to it as follows:
  - up to 112 gives 0;
  - up to 125 gives 1;
  - up to 137 gives 2;
  - up to 150 gives 3;
  - up to 162 gives 4;
  - up to 175 gives 5;
  - up to 187 gives 6;
  - up to 200 gives 7;
  - above 200 gives 0.
- R4: Lock is first polled in the cycle after clock-output enable is written, then every CLKS_PER_US cycles. After the polling edge that sees lock, `clk_pwrsave` returns to 1 and `seq_done` pulses one edge later. With lock already present, `seq_done` appears 11 edges after the request edge is counted as edge 1.
- R5: If POLL_LIMIT polls see no lock, power-save is still restored and `seq_done` pulses together with `seq_err`, 11 + (POLL_LIMIT-1)·CLKS_PER_US edges after the request.
- R6: A phase request sampled in idle first clears recovery enable (bit 17) and clock-output enable, and sets external select (bit 19) and loop enable. It then waits for `cko_readback` to be 0, writes the phase field (bits 23:20), sets clock-output enable, and waits for `cko_readback` to be 1. Finally it sets recovery enable and clears external select. With immediate readback, done comes 7 edges after the request.
- R7: The phase field holds the reflected Gray code of `phase_sel`. For example, 0,1,2,3,4,5,6,7 map to 0,1,3,2,6,7,5,4, and 8, 11 and 15 map to C, E and 8.
- R8: If a clock-output wait exhausts its POLL_LIMIT polls, the sequence stops at once: `seq_done` and `seq_err` pulse and no later step is written. On a first-wait expiry this happens 3 + (POLL_LIMIT-1)·CLKS_PER_US edges after the request.
- R9: In idle with no start request, `cdr_force_vld` copies `cdr_force_val` into recovery enable (bit 17) on the next edge and changes no other bit.
- R10: Start requests and `cdr_force_vld` are ignored while `busy` is 1. When an init request and a phase request arrive in the same idle cycle, the init request wins.
- R11: `seq_done` is a single-cycle pulse, and `seq_err` is never 1 without `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_rate_mhz | input | RATE_W | Interface clock rate in MHz, used for the band code |
| init_req | input | 1 | Start the initialisation sequence |
| phase_req | input | 1 | Start the phase sequence |
| phase_sel | input | 4 | Binary sampling phase, latched with `phase_req` |
| cdr_force_vld | input | 1 | Direct write of recovery enable, honoured in idle |
| cdr_force_val | input | 1 | Value for that direct write |
| dll_lock | input | 1 | Lock status from the loop |
| cko_readback | input | 1 | Clock-output enable as seen by the loop |
| dll_cfg | output | 32 | Loop control word |
| clk_pwrsave | output | 1 | Clock power-save enable |
| busy | output | 1 | A sequence is running |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| seq_err | output | 1 | Sequence ended on a poll timeout (valid with `seq_done`) |

## Verification
Every register step lands exactly one edge after the previous one. The bench therefore walks the initialisation and phase sequences edge by edge, and compares the full control word after each edge.

Poll results are due at fixed offsets: a fixed number of edges plus a whole number of CLKS_PER_US periods. The bench counts edges from the request to `seq_done` and compares the count with 11, 7, 386 (lock delayed by 300 cycles), 6136 (lock timeout) and 6128 (clock-output timeout).

All outputs are sampled on the falling edge, half a period after the edge that updates them.

// File: rtl/rxdl_pkg.sv
package rxdl_pkg;

    localparam int unsigned CFG_W        = 32;

    localparam int unsigned BIT_LOOP_EN  = 16;
    localparam int unsigned BIT_CDR_EN   = 17;
    localparam int unsigned BIT_CKO_EN   = 18;
    localparam int unsigned BIT_EXT_SEL  = 19;
    localparam int unsigned BIT_PWR_DN   = 29;
    localparam int unsigned BIT_RESET    = 30;

    localparam int unsigned PHASE_LSB    = 20;
    localparam int unsigned PHASE_W      = 4;

    localparam int unsigned BAND_LSB     = 24;
    localparam int unsigned NUM_BANDS    = 8;
    localparam int unsigned BAND_W       = $clog2(NUM_BANDS);

    // upper rate limit of each band, in MHz, lowest band first
    localparam int unsigned BAND_LIMIT_MHZ [NUM_BANDS] =
        '{112, 125, 137, 150, 162, 175, 187, 200};

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_I_PSAVE_OFF,
        ST_I_RST_SET,
        ST_I_PDN_SET,
        ST_I_FREQ,
        ST_I_RST_CLR,
        ST_I_PDN_CLR,
        ST_I_LOOP_EN,
        ST_I_CKO_SET,
        ST_I_LOCK_WAIT,
        ST_I_PSAVE_ON,
        ST_P_PREP,
        ST_P_CKO_LOW_WAIT,
        ST_P_SEL_WRITE,
        ST_P_CKO_SET,
        ST_P_CKO_HIGH_WAIT,
        ST_P_CDR_ON
    } seq_state_t;

endpackage

// File: rtl/rxdl_poll_timer.sv
module rxdl_poll_timer #(
    parameter int unsigned CLKS_PER_US = 125,
    parameter int unsigned POLL_LIMIT  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic poll_o,
    output logic last_o
);

    localparam int unsigned US_W = $clog2(CLKS_PER_US + 1);
    localparam int unsigned PC_W = $clog2(POLL_LIMIT + 1);

    logic [US_W-1:0] us_q;
    logic [PC_W-1:0] pc_q;

    assign poll_o = run_i && (us_q == '0);
    assign last_o = (pc_q == PC_W'(POLL_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_q <= '0;
            pc_q <= '0;
        end else if (clr_i) begin
            us_q <= '0;
            pc_q <= '0;
        end else if (run_i) begin
            us_q <= (us_q == US_W'(CLKS_PER_US - 1)) ? '0 : us_q + 1'b1;
            if (poll_o && !last_o) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    // R4: the first poll of a wait falls in the cycle right after the clear
    p_first_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && run_i) |-> poll_o);

    // R5: the poll count never passes its limit
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && poll_o && !clr_i) |=> (pc_q == PC_W'(POLL_LIMIT - 1)) || $past(clr_i));

endmodule

// File: rtl/rxdl_band_encode.sv
module rxdl_band_encode
    import rxdl_pkg::*;
#(
    parameter int unsigned RATE_W = 10
) (
    input  logic [RATE_W-1:0] rate_mhz_i,
    output logic [BAND_W-1:0] band_o
);

    logic [31:0]          rate32;
    logic [NUM_BANDS-1:0] fits;

    assign rate32 = 32'(rate_mhz_i);

    for (genvar gi = 0; gi < NUM_BANDS; gi++) begin : g_band
        assign fits[gi] = (rate32 <= BAND_LIMIT_MHZ[gi]);
    end

    // lowest band whose limit covers the rate; none covers it -> code 0
    always_comb begin
        band_o = '0;
        for (int i = NUM_BANDS - 1; i >= 0; i--) begin
            if (fits[i]) begin
                band_o = BAND_W'(i);
            end
        end
    end

endmodule

// File: rtl/rxdl_phase_gray.sv
module rxdl_phase_gray #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);

    for (genvar gi = 0; gi < W - 1; gi++) begin : g_bit
        assign gray_o[gi] = bin_i[gi] ^ bin_i[gi+1];
    end
    assign gray_o[W-1] = bin_i[W-1];

endmodule

// File: rtl/rxdl_sequencer.sv
module rxdl_sequencer
    import rxdl_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 125,
    parameter int unsigned POLL_LIMIT  = 50,
    parameter int unsigned RATE_W      = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATE_W-1:0]  clk_rate_mhz,
    input  logic               init_req,
    input  logic               phase_req,
    input  logic [PHASE_W-1:0] phase_sel,
    input  logic               cdr_force_vld,
    input  logic               cdr_force_val,
    input  logic               dll_lock,
    input  logic               cko_readback,
    output logic [CFG_W-1:0]   dll_cfg,
    output logic               clk_pwrsave,
    output logic               busy,
    output logic               seq_done,
    output logic               seq_err
);

    seq_state_t state_q, state_d;

    logic [CFG_W-1:0]   cfg_q;
    logic               pwrsave_q;
    logic               done_q;
    logic               err_q;
    logic               err_pend_q;
    logic [PHASE_W-1:0] phase_q;

    logic [BAND_W-1:0]  band_code;
    logic [PHASE_W-1:0] phase_gray;

    logic in_wait, timer_clr, poll_stb, poll_last;
    logic wait_want, wait_sample, poll_hit, poll_expire;

    rxdl_band_encode #(.RATE_W(RATE_W)) u_band (
        .rate_mhz_i (clk_rate_mhz),
        .band_o     (band_code)
    );

    rxdl_phase_gray #(.W(PHASE_W)) u_gray (
        .bin_i  (phase_q),
        .gray_o (phase_gray)
    );

    rxdl_poll_timer #(
        .CLKS_PER_US (CLKS_PER_US),
        .POLL_LIMIT  (POLL_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (timer_clr),
        .run_i  (in_wait),
        .poll_o (poll_stb),
        .last_o (poll_last)
    );

    // ---- wait decode ------------------------------------------------------
    always_comb begin
        in_wait     = state_q inside {ST_I_LOCK_WAIT, ST_P_CKO_LOW_WAIT, ST_P_CKO_HIGH_WAIT};
        timer_clr   = state_q inside {ST_I_CKO_SET, ST_P_PREP, ST_P_CKO_SET};
        wait_want   = (state_q != ST_P_CKO_LOW_WAIT);
        wait_sample = (state_q == ST_I_LOCK_WAIT) ? dll_lock : cko_readback;
        poll_hit    = poll_stb && (wait_sample == wait_want);
        poll_expire = poll_stb && (wait_sample != wait_want) && poll_last;
    end

    // ---- next state -------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (init_req)       state_d = ST_I_PSAVE_OFF;
                else if (phase_req) state_d = ST_P_PREP;
            end
            ST_I_PSAVE_OFF:  state_d = ST_I_RST_SET;
            ST_I_RST_SET:    state_d = ST_I_PDN_SET;
            ST_I_PDN_SET:    state_d = ST_I_FREQ;
            ST_I_FREQ:       state_d = ST_I_RST_CLR;
            ST_I_RST_CLR:    state_d = ST_I_PDN_CLR;
            ST_I_PDN_CLR:    state_d = ST_I_LOOP_EN;
            ST_I_LOOP_EN:    state_d = ST_I_CKO_SET;
            ST_I_CKO_SET:    state_d = ST_I_LOCK_WAIT;
            ST_I_LOCK_WAIT: begin
                if (poll_hit || poll_expire) state_d = ST_I_PSAVE_ON;
            end
            ST_I_PSAVE_ON:   state_d = ST_IDLE;
            ST_P_PREP:       state_d = ST_P_CKO_LOW_WAIT;
            ST_P_CKO_LOW_WAIT: begin
                if (poll_hit)         state_d = ST_P_SEL_WRITE;
                else if (poll_expire) state_d = ST_IDLE;
            end
            ST_P_SEL_WRITE:  state_d = ST_P_CKO_SET;
            ST_P_CKO_SET:    state_d = ST_P_CKO_HIGH_WAIT;
            ST_P_CKO_HIGH_WAIT: begin
                if (poll_hit)         state_d = ST_P_CDR_ON;
                else if (poll_expire) state_d = ST_IDLE;
            end
            ST_P_CDR_ON:     state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // ---- state register ---------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- outputs ----------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            pwrsave_q  <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_pend_q <= 1'b0;
            phase_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (init_req) begin
                        err_pend_q <= 1'b0;
                    end else if (phase_req) begin
                        phase_q <= phase_sel;
                    end else if (cdr_force_vld) begin
                        cfg_q[BIT_CDR_EN] <= cdr_force_val;
                    end
                end
                ST_I_PSAVE_OFF: pwrsave_q <= 1'b0;
                ST_I_RST_SET:   cfg_q[BIT_RESET]  <= 1'b1;
                ST_I_PDN_SET:   cfg_q[BIT_PWR_DN] <= 1'b1;
                ST_I_FREQ:      cfg_q[BAND_LSB +: BAND_W] <= band_code;
                ST_I_RST_CLR:   cfg_q[BIT_RESET]  <= 1'b0;
                ST_I_PDN_CLR:   cfg_q[BIT_PWR_DN] <= 1'b0;
                ST_I_LOOP_EN:   cfg_q[BIT_LOOP_EN] <= 1'b1;
                ST_I_CKO_SET:   cfg_q[BIT_CKO_EN]  <= 1'b1;
                ST_I_LOCK_WAIT: begin
                    if (poll_expire) err_pend_q <= 1'b1;
                end
                ST_I_PSAVE_ON: begin
                    pwrsave_q <= 1'b1;
                    done_q    <= 1'b1;
                    err_q     <= err_pend_q;
                end
                ST_P_PREP: begin
                    cfg_q[BIT_CDR_EN]  <= 1'b0;
                    cfg_q[BIT_CKO_EN]  <= 1'b0;
                    cfg_q[BIT_EXT_SEL] <= 1'b1;
                    cfg_q[BIT_LOOP_EN] <= 1'b1;
                end
                ST_P_CKO_LOW_WAIT, ST_P_CKO_HIGH_WAIT: begin
                    if (poll_expire) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end
                end
                ST_P_SEL_WRITE: cfg_q[PHASE_LSB +: PHASE_W] <= phase_gray;
                ST_P_CKO_SET:   cfg_q[BIT_CKO_EN] <= 1'b1;
                ST_P_CDR_ON: begin
                    cfg_q[BIT_CDR_EN]  <= 1'b1;
                    cfg_q[BIT_EXT_SEL] <= 1'b0;
                    done_q             <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign dll_cfg     = cfg_q;
    assign clk_pwrsave = pwrsave_q;
    assign busy        = (state_q != ST_IDLE);
    assign seq_done    = done_q;
    assign seq_err     = err_q;

    // ---- assertions -------------------------------------------------------
    // R2: reset is released only while power-down is still held
    p_rst_under_pdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q[BIT_RESET]) |-> cfg_q[BIT_PWR_DN]);

    // R2: power-save stays off for the whole lock wait
    p_psave_off_in_lock_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_I_LOCK_WAIT) |-> !pwrsave_q);

    // R6: the phase field only moves while the clock output is stopped
    p_sel_moves_cko_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q[PHASE_LSB +: PHASE_W]) |-> !cfg_q[BIT_CKO_EN]);

    // R6: recovery is parked under external select until the last step
    p_cdr_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P_CKO_HIGH_WAIT) |-> (!cfg_q[BIT_CDR_EN] && cfg_q[BIT_EXT_SEL]));

    // R10: control word untouched by the inputs while a wait is running
    p_wait_holds_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_wait) && in_wait) |-> $stable(cfg_q));

    // R11: done is a single-cycle pulse
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11: error only comes with done
    p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);

endmodule

// File: tb/test_rxdl_sequencer.sv
module test_rxdl_sequencer;

    localparam int unsigned CLKS = 125;
    localparam int unsigned POLLS = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  clk_rate_mhz = 10'd150;
    logic        init_req = 1'b0;
    logic        phase_req = 1'b0;
    logic [3:0]  phase_sel = 4'd0;
    logic        cdr_force_vld = 1'b0;
    logic        cdr_force_val = 1'b0;
    logic        dll_lock;
    logic        cko_readback;
    logic [31:0] dll_cfg;
    logic        clk_pwrsave, busy, seq_done, seq_err;

    int checks = 0;
    int failures = 0;

    // behavioural loop responder
    bit  lock_block = 1'b0;
    bit  cko_stuck_hi = 1'b0;
    int  lock_dly = 0;
    int  lock_cnt = 0;
    logic lock_cond;

    always #4 clk = ~clk;

    assign lock_cond = dll_cfg[16] && dll_cfg[18] && !dll_cfg[29] && !dll_cfg[30];
    always @(posedge clk) begin
        if (!lock_cond || lock_block) lock_cnt <= 0;
        else if (lock_cnt < 100000)   lock_cnt <= lock_cnt + 1;
    end
    assign dll_lock     = !lock_block && lock_cond && (lock_cnt >= lock_dly);
    assign cko_readback = cko_stuck_hi ? 1'b1 : dll_cfg[18];

    rxdl_sequencer #(.CLKS_PER_US(CLKS), .POLL_LIMIT(POLLS), .RATE_W(10)) i_rxdl_sequencer (
        .clk(clk), .rst_n(rst_n), .clk_rate_mhz(clk_rate_mhz),
        .init_req(init_req), .phase_req(phase_req), .phase_sel(phase_sel),
        .cdr_force_vld(cdr_force_vld), .cdr_force_val(cdr_force_val),
        .dll_lock(dll_lock), .cko_readback(cko_readback),
        .dll_cfg(dll_cfg), .clk_pwrsave(clk_pwrsave), .busy(busy),
        .seq_done(seq_done), .seq_err(seq_err)
    );

    // {rate[9:0], phase[3:0], band[2:0], gray[3:0]}
    localparam logic [20:0] VECS [11] = '{
        {10'd100, 4'd0,  3'd0, 4'h0},
        {10'd112, 4'd1,  3'd0, 4'h1},
        {10'd113, 4'd2,  3'd1, 4'h3},
        {10'd125, 4'd3,  3'd1, 4'h2},
        {10'd137, 4'd4,  3'd2, 4'h6},
        {10'd150, 4'd5,  3'd3, 4'h7},
        {10'd151, 4'd6,  3'd4, 4'h5},
        {10'd175, 4'd7,  3'd5, 4'h4},
        {10'd187, 4'd8,  3'd6, 4'hC},
        {10'd200, 4'd11, 3'd7, 4'hE},
        {10'd201, 4'd15, 3'd0, 4'h8}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic run_seq(input bit do_init, input bit do_phase, output int lat, output bit err);
        lat = 0;
        err = 1'b0;
        @(negedge clk);
        init_req  = do_init;
        phase_req = do_phase;
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            init_req  = 1'b0;
            phase_req = 1'b0;
            if (seq_done) begin
                err = seq_err;
                break;
            end
        end
    endtask

    task automatic step(input logic exp_ps, input logic [31:0] exp_cfg, input string tag);
        @(posedge clk);
        @(negedge clk);
        init_req  = 1'b0;
        phase_req = 1'b0;
        chk(dll_cfg == exp_cfg, tag, dll_cfg, exp_cfg);
        chk(clk_pwrsave == exp_ps, {tag, " pwrsave"}, 32'(clk_pwrsave), 32'(exp_ps));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int  lat;
        bit  err;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dll_cfg == 32'h0, "R1 cfg", dll_cfg, 32'h0);
        chk(clk_pwrsave && !busy && !seq_done && !seq_err, "R1 flags",
            {28'h0, clk_pwrsave, busy, seq_done, seq_err}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: initialisation walked edge by edge, rate 150 -> band 3
        init_req = 1'b1;
        step(1'b1, 32'h0000_0000, "R2 e1");
        chk(busy == 1'b1, "R2 busy", 32'(busy), 32'h1);
        step(1'b0, 32'h0000_0000, "R2 e2");
        step(1'b0, 32'h4000_0000, "R2 e3");
        step(1'b0, 32'h6000_0000, "R2 e4");
        step(1'b0, 32'h6300_0000, "R3 e5");
        step(1'b0, 32'h2300_0000, "R2 e6");
        step(1'b0, 32'h0300_0000, "R2 e7");
        step(1'b0, 32'h0301_0000, "R2 e8");
        step(1'b0, 32'h0305_0000, "R2 e9");
        step(1'b0, 32'h0305_0000, "R4 e10");
        step(1'b1, 32'h0305_0000, "R4 e11");
        chk(seq_done && !seq_err, "R4 done", {30'h0, seq_done, seq_err}, 32'h2);
        @(negedge clk);
        chk(!seq_done && !busy, "R11 done single", {30'h0, seq_done, busy}, 32'h0);

        // R6 R7: phase 5 -> Gray 7, walked edge by edge
        phase_sel = 4'd5;
        phase_req = 1'b1;
        step(1'b1, 32'h0305_0000, "R6 e1");
        step(1'b1, 32'h0309_0000, "R6 e2");
        step(1'b1, 32'h0309_0000, "R6 e3");
        step(1'b1, 32'h0379_0000, "R7 e4");
        step(1'b1, 32'h037D_0000, "R6 e5");
        step(1'b1, 32'h037D_0000, "R6 e6");
        step(1'b1, 32'h0377_0000, "R6 e7");
        chk(seq_done && !seq_err, "R6 done", {30'h0, seq_done, seq_err}, 32'h2);

        // R9: direct recovery enable writes in idle
        cdr_force_vld = 1'b1; cdr_force_val = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(dll_cfg == 32'h0375_0000, "R9 clear", dll_cfg, 32'h0375_0000);
        cdr_force_val = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(dll_cfg == 32'h0377_0000, "R9 set", dll_cfg, 32'h0377_0000);
        cdr_force_val = 1'b0;
        @(posedge clk); @(negedge clk);
        cdr_force_vld = 1'b0;
        chk(dll_cfg == 32'h0375_0000, "R9 clear again", dll_cfg, 32'h0375_0000);

        // R10: requests and direct writes while busy are ignored
        init_req = 1'b1;
        @(posedge clk); @(negedge clk);
        init_req = 1'b0;
        @(posedge clk); @(negedge clk);
        phase_sel = 4'd9; phase_req = 1'b1; cdr_force_vld = 1'b1; cdr_force_val = 1'b1;
        @(posedge clk); @(negedge clk);
        phase_req = 1'b0; cdr_force_vld = 1'b0;
        for (int k = 0; k < 50 && !seq_done; k++) begin
            @(posedge clk); @(negedge clk);
        end
        repeat (4) begin
            @(posedge clk); @(negedge clk);
            chk(!busy, "R10 no queued start", 32'(busy), 32'h0);
        end
        chk(dll_cfg == 32'h0375_0000, "R10 cfg untouched", dll_cfg, 32'h0375_0000);

        // R10: init wins over a simultaneous phase request
        phase_sel = 4'd3;
        run_seq(1'b1, 1'b1, lat, err);
        chk(lat == 11, "R10 init priority latency", lat, 11);
        chk(dll_cfg[23:20] == 4'h7, "R10 phase untouched", dll_cfg[23:20], 4'h7);

        // R3 R4 R6 R7: vector table
        foreach (VECS[i]) begin
            clk_rate_mhz = VECS[i][20:11];
            phase_sel    = VECS[i][10:7];
            run_seq(1'b1, 1'b0, lat, err);
            chk(lat == 11 && !err, "R4 init latency", {lat[30:0], err}, 32'd22);
            chk(dll_cfg[26:24] == VECS[i][6:4], "R3 band code", dll_cfg[26:24], VECS[i][6:4]);
            run_seq(1'b0, 1'b1, lat, err);
            chk(lat == 7 && !err, "R6 phase latency", {lat[30:0], err}, 32'd14);
            chk(dll_cfg[23:20] == VECS[i][3:0], "R7 gray field", dll_cfg[23:20], VECS[i][3:0]);
            chk(dll_cfg[19:16] == 4'b0111, "R6 final control", dll_cfg[19:16], 4'b0111);
        end

        // R4: lock arriving 300 cycles late is seen at the fourth poll
        lock_dly = 300;
        run_seq(1'b1, 1'b0, lat, err);
        chk(lat == 11 + 3 * CLKS && !err, "R4 delayed lock", lat, 11 + 3 * CLKS);
        lock_dly = 0;

        // R5: lock never comes
        lock_block = 1'b1;
        run_seq(1'b1, 1'b0, lat, err);
        chk(lat == 11 + (POLLS - 1) * CLKS, "R5 timeout latency", lat, 11 + (POLLS - 1) * CLKS);
        chk(err == 1'b1 && clk_pwrsave == 1'b1, "R5 err and pwrsave",
            {30'h0, err, clk_pwrsave}, 32'h3);
        lock_block = 1'b0;

        // R8: clock output never reads low
        cko_stuck_hi = 1'b1;
        phase_sel = 4'd2;
        run_seq(1'b0, 1'b1, lat, err);
        chk(lat == 3 + (POLLS - 1) * CLKS && err, "R8 timeout latency", lat, 3 + (POLLS - 1) * CLKS);
        chk(dll_cfg[23:20] == 4'h8, "R8 phase not written", dll_cfg[23:20], 4'h8);
        chk(dll_cfg[19:16] == 4'b1001, "R8 stopped after prep", dll_cfg[19:16], 4'b1001);
        @(negedge clk);
        chk(!seq_done && !seq_err && !busy, "R11 after error",
            {29'h0, seq_done, seq_err, busy}, 32'h0);
        cko_stuck_hi = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule